// File: doc/BRIEF.md
# Carrier Frequency Discriminator with Weighted Frequency Correction

This block turns a stream of carrier phase error samples into frequency information for a carrier tracking loop. Each accepted sample is differenced against the sample accepted a selectable number of steps earlier. The result is proportional to carrier frequency offset, and the length of the gap sets the discriminator gain. A second stage adds a signed offset to that difference and then shifts it arithmetically to the right, which forms a frequency error term suited to frequency-shift keyed signals. With both controls at zero the difference passes through untouched, for phase-shift keyed use.

The frequency error is then multiplied by a signed weight to form a correction term for the lag path of the loop filter. A single control bit forces that correction to zero when automatic frequency control is not wanted. All three results are registered together and appear one clock after each valid sample, alongside a one-cycle valid pulse. The controls are read on the same clock edge as the sample they apply to.

Top module: `freq_disc_afc`

## Requirements
- R1: While `rst` is high, all outputs are zero and `out_valid` is low, and every stored history entry is cleared to zero.
- R2: On a valid sample, `disc_out` equals the current sample minus the sample accepted N valid samples earlier, where N = `gap_sel` + 1 (so N ranges 1 to 16 and `gap_sel` = 15 selects 16).
- R3: Until N samples have been accepted since reset, the "N samples earlier" value is taken as zero.
- R4: The difference is taken modulo 2^10 in two's complement, so that 400 followed by -500 at N = 1 gives 124.
- R5: `ferr_out` equals (`disc` + `ferr_offset`) taken modulo 2^10 as a signed value, then arithmetically shifted right by `ferr_shift` (0 to 7).
- R6: With `ferr_offset` = 0 and `ferr_shift` = 0, `ferr_out` equals `disc_out`.
- R7: `afc_out` equals the signed product `ferr` × `afc_weight` at full 18-bit width.
- R8: When `afc_null` is high with a valid sample, `afc_out` becomes zero, and `disc_out` and `ferr_out` are unaffected.
- R9: The outputs update only on the clock edge that accepts a valid sample and hold otherwise. `out_valid` is high for exactly the one cycle after each accepted sample.
- R10: A change of `gap_sel` presented together with a sample applies to that sample, using history already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_in | input | 10 | Signed phase error sample |
| phase_vld | input | 1 | Sample strobe |
| gap_sel | input | 4 | Differencing gap minus one |
| ferr_offset | input | 10 | Signed offset added to the difference |
| ferr_shift | input | 3 | Arithmetic right shift amount |
| afc_weight | input | 8 | Signed correction weight |
| afc_null | input | 1 | Forces the correction to zero |
| out_valid | output | 1 | Pulse one cycle after each sample |
| disc_out | output | 10 | Registered discriminator value |
| ferr_out | output | 10 | Registered frequency error |
| afc_out | output | 18 | Registered weighted correction |

## Verification
Two cases can coincide on one accepting edge. In the first, a new differencing gap is selected on the same edge that stores a sample, so the history read and the history write fall together. The bench presents a new `gap_sel` together with a sample and judges `disc_out` against the sample that lies exactly N entries back in its own record. In the second, nulling lands on the same edge as a nonzero weighted error. The bench asserts `afc_null` on a sample with a large offset, shift and weight, and requires `afc_out` to be zero while `disc_out` and `ferr_out` still match the un-nulled arithmetic.

// File: rtl/fda_pkg.sv
package fda_pkg;

    localparam int PH_W       = 10;
    localparam int HIST_DEPTH = 16;
    localparam int PTR_W      = $clog2(HIST_DEPTH);
    localparam int SH_W       = 3;
    localparam int WT_W       = 8;
    localparam int AFC_W      = PH_W + WT_W;

    typedef logic signed [PH_W-1:0]  phase_t;
    typedef logic        [PTR_W-1:0] ptr_t;
    typedef logic        [SH_W-1:0]  shift_t;
    typedef logic signed [WT_W-1:0]  weight_t;
    typedef logic signed [AFC_W-1:0] afc_t;

    typedef struct packed {
        phase_t disc;
        phase_t ferr;
        afc_t   afc;
    } fda_result_t;

    // Entry holding the sample (sel+1) writes before the one at wptr.
    function automatic ptr_t tap_ptr(ptr_t wptr, ptr_t sel);
        ptr_t r;
        r = wptr - sel - ptr_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/fda_phase_history.sv
module fda_phase_history
    import fda_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  phase_t wr_data,
    input  ptr_t   sel,
    output phase_t past
);

    phase_t mem [HIST_DEPTH];
    ptr_t   wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            for (int i = 0; i < HIST_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wptr] <= wr_data;
            wptr      <= wptr + ptr_t'(1);
        end
    end

    // Read precedes the write on the same edge, so a gap equal to the
    // full depth returns the entry about to be overwritten.
    assign past = mem[tap_ptr(wptr, sel)];

endmodule

// File: rtl/fda_err_path.sv
module fda_err_path
    import fda_pkg::*;
(
    input  phase_t cur,
    input  phase_t past,
    input  phase_t offset,
    input  shift_t shift,
    output phase_t disc,
    output phase_t ferr
);

    phase_t biased;

    always_comb begin
        disc   = cur - past;
        biased = disc + offset;
        ferr   = biased >>> shift;
    end

endmodule

// File: rtl/fda_afc_scale.sv
module fda_afc_scale
    import fda_pkg::*;
(
    input  phase_t  ferr,
    input  weight_t weight,
    input  logic    null_en,
    output afc_t    afc
);

    afc_t prod;

    always_comb begin
        prod = ferr * weight;
        afc  = null_en ? '0 : prod;
    end

endmodule

// File: rtl/freq_disc_afc.sv
module freq_disc_afc
    import fda_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [PH_W-1:0] phase_in,
    input  logic                   phase_vld,
    input  logic [PTR_W-1:0]       gap_sel,
    input  logic signed [PH_W-1:0] ferr_offset,
    input  logic [SH_W-1:0]        ferr_shift,
    input  logic signed [WT_W-1:0] afc_weight,
    input  logic                   afc_null,
    output logic                   out_valid,
    output logic signed [PH_W-1:0] disc_out,
    output logic signed [PH_W-1:0] ferr_out,
    output logic signed [AFC_W-1:0] afc_out
);

    phase_t      past;
    fda_result_t nxt;
    fda_result_t res_q;

    fda_phase_history u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (phase_vld),
        .wr_data (phase_in),
        .sel     (gap_sel),
        .past    (past)
    );

    fda_err_path u_err (
        .cur    (phase_in),
        .past   (past),
        .offset (ferr_offset),
        .shift  (ferr_shift),
        .disc   (nxt.disc),
        .ferr   (nxt.ferr)
    );

    fda_afc_scale u_afc (
        .ferr    (nxt.ferr),
        .weight  (afc_weight),
        .null_en (afc_null),
        .afc     (nxt.afc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= phase_vld;
            if (phase_vld) begin
                res_q <= nxt;
            end
        end
    end

    assign disc_out = res_q.disc;
    assign ferr_out = res_q.ferr;
    assign afc_out  = res_q.afc;

endmodule

// File: rtl/fda_checker.sv
module fda_checker
    import fda_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    phase_vld,
    input logic signed [PH_W-1:0]  ferr_offset,
    input logic [SH_W-1:0]         ferr_shift,
    input logic                    afc_null,
    input logic                    out_valid,
    input logic signed [PH_W-1:0]  disc_out,
    input logic signed [PH_W-1:0]  ferr_out,
    input logic signed [AFC_W-1:0] afc_out
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (out_valid == 1'b0 && disc_out == '0 && ferr_out == '0 && afc_out == '0));

    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        phase_vld |=> out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !phase_vld |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !phase_vld |=> ($stable(disc_out) && $stable(ferr_out) && $stable(afc_out)));

    a_r8_null_zero: assert property (@(posedge clk) disable iff (rst)
        (phase_vld && afc_null) |=> afc_out == '0);

    a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
        (phase_vld && ferr_offset == '0 && ferr_shift == '0) |=> ferr_out == disc_out);

endmodule

bind freq_disc_afc fda_checker u_fda_checker (
    .clk         (clk),
    .rst         (rst),
    .phase_vld   (phase_vld),
    .ferr_offset (ferr_offset),
    .ferr_shift  (ferr_shift),
    .afc_null    (afc_null),
    .out_valid   (out_valid),
    .disc_out    (disc_out),
    .ferr_out    (ferr_out),
    .afc_out     (afc_out)
);

// File: tb/freq_disc_afc_bench.sv
module freq_disc_afc_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [9:0]  phase_in = '0;
    logic               phase_vld = 1'b0;
    logic [3:0]         gap_sel = '0;
    logic signed [9:0]  ferr_offset = '0;
    logic [2:0]         ferr_shift = '0;
    logic signed [7:0]  afc_weight = '0;
    logic               afc_null = 1'b0;
    logic               out_valid;
    logic signed [9:0]  disc_out;
    logic signed [9:0]  ferr_out;
    logic signed [17:0] afc_out;

    int checks = 0;
    int errors = 0;
    logic signed [9:0] hist [$];

    always #4 clk = ~clk;

    freq_disc_afc u_freq_disc_afc (
        .clk(clk), .rst(rst), .phase_in(phase_in), .phase_vld(phase_vld),
        .gap_sel(gap_sel), .ferr_offset(ferr_offset), .ferr_shift(ferr_shift),
        .afc_weight(afc_weight), .afc_null(afc_null), .out_valid(out_valid),
        .disc_out(disc_out), .ferr_out(ferr_out), .afc_out(afc_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        phase_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(disc_out == 0, "R1 disc", disc_out, 0);
        chk(ferr_out == 0, "R1 ferr", ferr_out, 0);
        chk(afc_out == 0, "R1 afc", afc_out, 0);
        rst = 1'b0;
        hist.delete();
    endtask

    // Presents one sample; checks all outputs one cycle later.
    task automatic send(input logic signed [9:0] s, input int n,
                        input logic signed [9:0] off, input int sh,
                        input logic signed [7:0] w, input bit nul, input string req);
        logic signed [9:0]  p;
        logic signed [9:0]  d;
        logic signed [9:0]  sm;
        logic signed [9:0]  f;
        logic signed [17:0] a;
        p  = (hist.size() >= n) ? hist[hist.size() - n] : 10'sd0;
        d  = s - p;
        sm = d + off;
        f  = sm >>> sh;
        a  = f * w;
        if (nul) a = '0;
        phase_in = s;
        gap_sel = 4'(n - 1);
        ferr_offset = off;
        ferr_shift = 3'(sh);
        afc_weight = w;
        afc_null = nul;
        phase_vld = 1'b1;
        hist.push_back(s);
        @(negedge clk);
        phase_vld = 1'b0;
        chk(out_valid == 1'b1, {req, " R9 valid"}, out_valid, 1);
        chk(disc_out == d, {req, " disc"}, disc_out, d);
        chk(ferr_out == f, {req, " ferr"}, ferr_out, f);
        chk(afc_out == a, {req, " afc"}, afc_out, a);
    endtask

    task automatic t_fill();
        // R3: early samples see zero history
        send(10'sd5, 4, 0, 0, 0, 0, "R3 first");
        send(10'sd9, 4, 0, 0, 0, 0, "R3 second");
        send(10'sd20, 4, 0, 0, 0, 0, "R3 third");
        send(10'sd33, 4, 0, 0, 0, 0, "R3 fourth");
        send(10'sd40, 4, 0, 0, 0, 0, "R2 gap4");
        send(-10'sd7, 4, 0, 0, 0, 0, "R2 gap4 b");
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 20; i++) begin
            send(10'(i * 23 - 200), 16, 0, 0, 0, 0, "R2 gap16");
        end
        for (int i = 0; i < 6; i++) begin
            send(10'(i * i * 7), 1, 0, 0, 0, 0, "R2 gap1");
        end
    endtask

    task automatic t_wrap();
        send(10'sd400, 1, 0, 0, 0, 0, "R4 setup");
        send(-10'sd500, 1, 0, 0, 0, 0, "R4 wrap");
        chk(disc_out == 10'sd124, "R4 literal", disc_out, 124);
        send(10'sd500, 1, 0, 0, 0, 0, "R4 setup b");
        send(-10'sd500, 1, 0, 0, 0, 0, "R4 wrap b");
        chk(disc_out == 10'sd24, "R4 literal b", disc_out, 24);
    endtask

    task automatic t_err();
        send(10'sd100, 1, 10'sd37, 2, 0, 0, "R5 off shift");
        send(-10'sd60, 1, -10'sd11, 3, 0, 0, "R5 negative");
        send(10'sd300, 1, 10'sd400, 1, 0, 0, "R5 offset wrap");
        send(10'sd50, 1, 10'sd511, 7, 0, 0, "R5 max shift");
        send(10'sd77, 2, 0, 0, 0, 0, "R6 bypass");
        send(-10'sd300, 2, 0, 0, 0, 0, "R6 bypass b");
        chk(ferr_out == disc_out, "R6 equal", ferr_out, disc_out);
    endtask

    task automatic t_afc();
        send(10'sd200, 1, 10'sd3, 0, 8'sd127, 0, "R7 max weight");
        send(-10'sd311, 1, 0, 0, -8'sd128, 0, "R7 min weight");
        send(10'sd12, 3, -10'sd9, 1, -8'sd5, 0, "R7 mixed");
    endtask

    task automatic t_null();
        // R8: nulling coincides with a large nonzero weighted error
        send(10'sd250, 1, 10'sd90, 1, 8'sd100, 1, "R8 null");
        chk(afc_out == 0, "R8 zero", afc_out, 0);
        send(-10'sd250, 1, 10'sd90, 1, 8'sd100, 0, "R8 release");
    endtask

    task automatic t_hold();
        logic signed [9:0]  d0;
        logic signed [9:0]  f0;
        logic signed [17:0] a0;
        send(10'sd123, 1, 10'sd4, 1, 8'sd9, 0, "R9 setup");
        d0 = disc_out; f0 = ferr_out; a0 = afc_out;
        phase_in = -10'sd400;
        ferr_offset = 10'sd77;
        afc_weight = -8'sd40;
        afc_null = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 pulse ends", out_valid, 0);
        chk(disc_out == d0, "R9 disc hold", disc_out, d0);
        chk(ferr_out == f0, "R9 ferr hold", ferr_out, f0);
        chk(afc_out == a0, "R9 afc hold", afc_out, a0);
    endtask

    task automatic t_switch();
        for (int i = 0; i < 16; i++) begin
            send(10'(i * 31), 16, 0, 0, 0, 0, "R10 load");
        end
        send(10'sd1, 5, 0, 0, 0, 0, "R10 switch to 5");
        send(10'sd2, 16, 0, 0, 0, 0, "R10 switch to 16");
        send(10'sd3, 1, 0, 0, 0, 0, "R10 switch to 1");
    endtask

    task automatic t_reset_history();
        // R1: history cleared by reset, so gap 16 sees zero again
        do_reset();
        send(10'sd45, 16, 0, 0, 0, 0, "R1 history cleared");
        chk(disc_out == 10'sd45, "R1 history literal", disc_out, 45);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_fill();
        t_gaps();
        t_wrap();
        t_err();
        t_afc();
        t_null();
        t_hold();
        t_switch();
        t_reset_history();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule